// File: doc/BRIEF.md
# MDIO Management Master

This block runs station-management transactions on a shared two-wire management bus. It drives the clock line and the data line, and it samples the data line when a PHY drives it back. A host hands over one request at a time: read or write, the short or the extended addressing form, a 5-bit PHY address, a 5-bit register or device address, a 16-bit register address for the extended form, and the write data. When the transaction finishes, the block pulses `rsp_done` for one cycle. With that pulse it presents the read data and a turnaround-error flag.

Every frame opens with a 32-bit run of ones. After that come the start and opcode pairs, the two address fields, a turnaround and 16 data bits, all most significant bit first. An extended access runs as two frames back to back: first an address frame that carries the 16-bit register address, then the read or write frame. On a read, the master checks that the PHY pulls the turnaround bit low. If it does not, and the PHY is not exempted by a per-PHY mask, the master clocks the bus 32 more times to flush it, returns all ones and raises the error flag.

The clock line is built from the system clock with a parameter for each half-period, so timing needs no software. The host side takes requests through a valid/ready handshake. `req_ready` equals `!busy`: a request presented while a transaction runs simply waits, or is lost if the host drops it. The response is a one-cycle pulse with no back-pressure. The host must capture `rsp_rdata` and `rsp_ta_err` in the cycle `rsp_done` is high. Both values then hold until the next response.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction runs, `mdc` is 0, `mdio_oe` is 0, `busy` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until the `rsp_done` cycle, `busy` is 1 and `req_ready` is 0, and requests presented in that time start nothing.
- R3: Every frame begins with 32 ones, then a start pair and an opcode pair. Short form: start 01, opcode taken from `c22_rd_op` or `c22_wr_op` (the host drives 10 and 01 for standard parts). Extended form: start 00, opcode 00 for the address frame, 11 for read, 01 for write.
- R4: After the opcode pair, the master drives the 5-bit PHY address and then the 5-bit register or device address, MSB first.
- R5: In write frames and extended address frames, the master drives turnaround 1 then 0 and then the 16 payload bits MSB first. It then drives one more clock slot with `mdio_oe` low, so 64 driven slots plus one released slot.
- R6: In a read frame, `mdio_oe` is high for the first 46 slots only. Slot 46 is the turnaround. If the PHY drives it 0, slots 47 to 62 are taken as data MSB first and slot 63 is idle. `rsp_done` then follows with that data and `rsp_ta_err` = 0.
- R7: If the read turnaround is 1 and bit [phy] of `ta_ignore_mask` is 0, the frame runs 32 more slots after the turnaround. The result is `rsp_rdata` = 16'hFFFF with `rsp_ta_err` = 1.
- R8: If bit [phy] of `ta_ignore_mask` is 1, a turnaround of 1 is accepted, and the data and error flag are the same as in R6.
- R9: An extended request issues an address frame whose payload is `req_addr` and whose register field is `req_reg`. It then issues the read or write frame with the same PHY and device address, with no gap in the clock.
- R10: `mdc` low halves last `LO_DIV` clocks. High halves last `HI_DIV` clocks in slots the master drives and `RX_HI_DIV` clocks in released slots. `mdio_o` and `mdio_oe` change only on the edge where `mdc` falls.
- R11: For a write, `rsp_rdata` is 0 and `rsp_ta_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (equals !busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = extended addressing form |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address (short) or device address (extended) |
| req_addr | input | 16 | Register address for the extended address frame |
| req_wdata | input | 16 | Write data |
| c22_rd_op | input | 2 | Short-form read opcode |
| c22_wr_op | input | 2 | Short-form write opcode |
| ta_ignore_mask | input | 32 | Per-PHY turnaround-check exemption |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, 0 after a write |
| rsp_ta_err | output | 1 | Turnaround error on the last read |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Two things can meet in the same cycle: a new request and a transaction still running, or its completion pulse. The bench provokes this in two ways. It pulses a one-cycle request while a write runs, and it holds a second request on the handshake during that write so that it is taken on the first edge after `rsp_done`. The result is judged on the bus. The frames on the wire must match the expected queue in order, with no frame for the dropped pulse and the held request starting with no lost cycle. The scoreboard must also see exactly one response per taken request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_BITS  = 5;
  localparam int DATA_BITS  = 16;
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_BITS;  // driven slots of a read
  localparam int FRM_BITS   = HDR_BITS + 2 + DATA_BITS;      // driven slots of a write
  localparam int FLUSH_BITS = 32;
  localparam int SLOT_W     = $clog2(HDR_BITS + 1 + FLUSH_BITS + 1);

  localparam logic [1:0] START_SHORT = 2'b01;
  localparam logic [1:0] START_EXT   = 2'b00;
  localparam logic [1:0] OPX_ADDR    = 2'b00;
  localparam logic [1:0] OPX_READ    = 2'b11;
  localparam logic [1:0] OPX_WRITE   = 2'b01;

  typedef logic [FRM_BITS-1:0] frame_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mst_state_e;

  function automatic frame_t frame_word(input logic [1:0] st, input logic [1:0] op,
                                        input logic [ADDR_BITS-1:0] phy,
                                        input logic [ADDR_BITS-1:0] rg,
                                        input logic [DATA_BITS-1:0] pay);
    return {{PRE_BITS{1'b1}}, st, op, phy, rg, 2'b10, pay};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int LO_DIV    = 25,
  parameter int HI_DIV    = 25,
  parameter int RX_HI_DIV = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rx_slot,
  output logic mdc,
  output logic slot_end
);
  localparam int MAX_A = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV;
  localparam int MAX_D = (MAX_A > RX_HI_DIV) ? MAX_A : RX_HI_DIV;
  localparam int CW    = $clog2(MAX_D + 1);

  logic [CW-1:0] cnt;
  logic          high;
  logic [CW-1:0] lo_end;
  logic [CW-1:0] hi_end;

  assign lo_end   = CW'(LO_DIV - 1);
  assign hi_end   = rx_slot ? CW'(RX_HI_DIV - 1) : CW'(HI_DIV - 1);
  assign slot_end = run & high & (cnt == hi_end);
  assign mdc      = high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      high <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      high <= 1'b0;
    end else if (!high) begin
      if (cnt == lo_end) begin
        cnt  <= '0;
        high <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == hi_end) begin
        cnt  <= '0;
        high <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_rx_path.sv
module mdio_rx_path
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 sample,
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 mdio_i,
  input  logic                 ignore,
  output logic                 ta_bad,
  output logic [DATA_BITS-1:0] rdata
);
  localparam logic [SLOT_W-1:0] TA_SLOT    = SLOT_W'(HDR_BITS);
  localparam logic [SLOT_W-1:0] DATA_FIRST = SLOT_W'(HDR_BITS + 1);
  localparam logic [SLOT_W-1:0] DATA_LAST  = SLOT_W'(HDR_BITS + DATA_BITS);

  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_bad <= 1'b0;
      shreg  <= '0;
    end else if (clear) begin
      ta_bad <= 1'b0;
      shreg  <= '0;
    end else if (sample) begin
      if (slot == TA_SLOT) begin
        ta_bad <= mdio_i & ~ignore;
      end else if (slot >= DATA_FIRST && slot <= DATA_LAST && !ta_bad) begin
        shreg <= {shreg[DATA_BITS-2:0], mdio_i};
      end
    end
  end

  assign rdata = ta_bad ? {DATA_BITS{1'b1}} : shreg;

  // R7
  ta_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ta_bad) |-> $past(mdio_i) && !$past(ignore));
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_c45,
  input  logic [ADDR_BITS-1:0] req_phy,
  input  logic [ADDR_BITS-1:0] req_reg,
  input  logic [DATA_BITS-1:0] req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic [1:0]           c22_rd_op,
  input  logic [1:0]           c22_wr_op,
  input  logic [31:0]          ta_ignore_mask,
  input  logic                 slot_end,
  input  logic                 mdio_i,
  output logic                 run,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 busy,
  output logic                 rsp_done,
  output logic [DATA_BITS-1:0] rsp_rdata,
  output logic                 rsp_ta_err
);
  localparam logic [SLOT_W-1:0] RD_DRIVE  = SLOT_W'(HDR_BITS);
  localparam logic [SLOT_W-1:0] WR_DRIVE  = SLOT_W'(FRM_BITS);
  localparam logic [SLOT_W-1:0] WR_LAST   = SLOT_W'(FRM_BITS);
  localparam logic [SLOT_W-1:0] RD_LAST   = SLOT_W'(FRM_BITS - 1);
  localparam logic [SLOT_W-1:0] FLUSH_END = SLOT_W'(HDR_BITS + FLUSH_BITS);

  mst_state_e           state;
  logic                 addr_phase;
  logic                 is_read;
  logic                 lat_write;
  logic                 lat_ign;
  logic [ADDR_BITS-1:0] lat_phy;
  logic [ADDR_BITS-1:0] lat_reg;
  logic [DATA_BITS-1:0] lat_wdata;
  logic [SLOT_W-1:0]    slot;
  frame_t               tx;
  logic                 ta_bad;
  logic [DATA_BITS-1:0] rx_data;
  logic [SLOT_W-1:0]    last_slot;
  logic                 accept;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign run       = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);
  assign rsp_done  = (state == ST_DONE);
  assign mdio_oe   = run && (slot < (is_read ? RD_DRIVE : WR_DRIVE));
  assign mdio_o    = mdio_oe & tx[FRM_BITS-1];
  assign last_slot = !is_read ? WR_LAST : (ta_bad ? FLUSH_END : RD_LAST);

  mdio_rx_path u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state == ST_IDLE),
    .sample (slot_end && is_read),
    .slot   (slot),
    .mdio_i (mdio_i),
    .ignore (lat_ign),
    .ta_bad (ta_bad),
    .rdata  (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_phase <= 1'b0;
      is_read    <= 1'b0;
      lat_write  <= 1'b0;
      lat_ign    <= 1'b0;
      lat_phy    <= '0;
      lat_reg    <= '0;
      lat_wdata  <= '0;
      slot       <= '0;
      tx         <= '0;
      rsp_rdata  <= '0;
      rsp_ta_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            lat_write <= req_write;
            lat_ign   <= ta_ignore_mask[req_phy];
            lat_phy   <= req_phy;
            lat_reg   <= req_reg;
            lat_wdata <= req_wdata;
            slot      <= '0;
            state     <= ST_RUN;
            if (req_c45) begin
              tx         <= frame_word(START_EXT, OPX_ADDR, req_phy, req_reg, req_addr);
              is_read    <= 1'b0;
              addr_phase <= 1'b1;
            end else begin
              tx         <= frame_word(START_SHORT, req_write ? c22_wr_op : c22_rd_op,
                                       req_phy, req_reg, req_wdata);
              is_read    <= !req_write;
              addr_phase <= 1'b0;
            end
          end
        end
        ST_RUN: begin
          if (slot_end) begin
            if (slot == last_slot) begin
              if (addr_phase) begin
                tx         <= frame_word(START_EXT, lat_write ? OPX_WRITE : OPX_READ,
                                         lat_phy, lat_reg, lat_wdata);
                is_read    <= !lat_write;
                addr_phase <= 1'b0;
                slot       <= '0;
              end else begin
                state      <= ST_DONE;
                rsp_rdata  <= is_read ? rx_data : '0;
                rsp_ta_err <= is_read & ta_bad;
              end
            end else begin
              slot <= slot + 1'b1;
              tx   <= {tx[FRM_BITS-2:0], 1'b0};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe && !run);

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && $past(is_read)) |-> !$past(mdio_oe));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int LO_DIV    = 25,
  parameter int HI_DIV    = 25,
  parameter int RX_HI_DIV = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_c45,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  c22_rd_op,
  input  logic [1:0]  c22_wr_op,
  input  logic [31:0] ta_ignore_mask,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        rsp_ta_err,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic run;
  logic slot_end;

  mdio_mdc_gen #(
    .LO_DIV    (LO_DIV),
    .HI_DIV    (HI_DIV),
    .RX_HI_DIV (RX_HI_DIV)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .rx_slot  (!mdio_oe),
    .mdc      (mdc),
    .slot_end (slot_end)
  );

  mdio_frame_ctl u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_c45        (req_c45),
    .req_phy        (req_phy),
    .req_reg        (req_reg),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .c22_rd_op      (c22_rd_op),
    .c22_wr_op      (c22_wr_op),
    .ta_ignore_mask (ta_ignore_mask),
    .slot_end       (slot_end),
    .mdio_i         (mdio_i),
    .run            (run),
    .mdio_o         (mdio_o),
    .mdio_oe        (mdio_oe),
    .busy           (busy),
    .rsp_done       (rsp_done),
    .rsp_rdata      (rsp_rdata),
    .rsp_ta_err     (rsp_ta_err)
  );

  assign req_ready = !busy;

  // R2
  take_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R10
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable({mdio_o, mdio_oe}));

  // R5
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !mdio_oe && !mdc);

  // R7
  err_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_ta_err |-> rsp_rdata == 16'hFFFF);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LO   = 25;
  localparam int HI   = 25;
  localparam int RXHI = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_c45 = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  c22_rd_op = 2'b10;
  logic [1:0]  c22_wr_op = 2'b01;
  logic [31:0] ta_ignore_mask = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        rsp_ta_err;
  logic        busy;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_master #(.LO_DIV(LO), .HI_DIV(HI), .RX_HI_DIV(RXHI)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_c45(req_c45), .req_phy(req_phy), .req_reg(req_reg),
    .req_addr(req_addr), .req_wdata(req_wdata), .c22_rd_op(c22_rd_op),
    .c22_wr_op(c22_wr_op), .ta_ignore_mask(ta_ignore_mask), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
    int          oe;
  } frm_t;
  typedef struct {
    logic [15:0] d;
    logic        e;
  } rsp_t;

  frm_t frm_q[$];
  rsp_t rsp_q[$];
  logic        phy_ta_bad = 1'b0;
  logic [15:0] phy_data = '0;

  function automatic frm_t mk_frame(input logic [1:0] st, input logic [1:0] op,
                                    input logic [4:0] phy, input logic [4:0] rg,
                                    input logic [15:0] pay, input bit rd);
    frm_t f;
    f.bits = {32'hFFFF_FFFF, st, op, phy, rg, (rd ? 18'h0 : {2'b10, pay})};
    f.mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    f.oe   = rd ? 46 : 64;
    return f;
  endfunction

  // PHY model and timing monitor, sampled away from the active edge
  logic        mdc_q = 1'b0;
  int          r = 0;
  int          oec = 0;
  int          flen = 0;
  logic [63:0] cap = '0;
  int          lo_c = 0;
  int          hi_c = 0;
  logic        hi_oe = 1'b0;
  logic        tim_bad = 1'b0;

  always @(negedge clk) begin
    if (!busy) begin
      r = 0; oec = 0; flen = 0; cap = '0; lo_c = 0; hi_c = 0;
      mdio_i = 1'b1;
    end else begin
      // R10 timing of each half
      if (mdc && !mdc_q) begin
        if (lo_c != LO) tim_bad = 1'b1;
        hi_c = 1; hi_oe = mdio_oe;
      end else if (mdc) begin
        hi_c++;
      end else if (mdc_q) begin
        if (hi_c != (hi_oe ? HI : RXHI)) tim_bad = 1'b1;
        lo_c = 1;
      end else begin
        lo_c++;
      end
      if (mdc && !mdc_q) begin
        if (r < 64) cap[63 - r] = mdio_o;
        if (mdio_oe) oec++;
        if (r == 45) begin
          logic rd;
          rd = (cap[31:30] == 2'b01 && cap[29:28] == c22_rd_op) ||
               (cap[31:30] == 2'b00 && cap[29:28] == 2'b11);
          if (rd) flen = (phy_ta_bad && !ta_ignore_mask[cap[27:23]]) ? 79 : 64;
          else    flen = 65;
        end
        if (r == 46) mdio_i = phy_ta_bad;
        else if (r >= 47 && r <= 62) mdio_i = phy_data[62 - r];
        else mdio_i = 1'b1;
        if (r == flen - 1) begin
          if (frm_q.size() == 0) begin
            chk(0, "R2 unexpected frame", cap, 64'h0);
          end else begin
            frm_t f;
            f = frm_q.pop_front();
            chk(((cap ^ f.bits) & f.mask) == 0, "R3/R4/R5/R6/R9 frame bits", cap, f.bits);
            chk(oec == f.oe, "R5/R6 driven slot count", 64'(oec), 64'(f.oe));
          end
          r = 0; oec = 0; cap = '0; flen = 0;
        end else begin
          r++;
        end
      end
    end
    mdc_q = mdc;
  end

  // Scoreboard monitor for responses
  always @(negedge clk) begin
    if (rsp_done) begin
      if (rsp_q.size() == 0) begin
        chk(0, "R2 unexpected response", 64'(rsp_rdata), 64'h0);
      end else begin
        rsp_t x;
        x = rsp_q.pop_front();
        chk(rsp_rdata == x.d && rsp_ta_err == x.e, "R6/R7/R8/R11 response",
            {47'h0, rsp_ta_err, rsp_rdata}, {47'h0, x.e, x.d});
      end
      chk(!tim_bad, "R10 mdc half-period timing", 64'(tim_bad), 64'h0);
      tim_bad = 1'b0;
    end
  end

  task automatic send(input logic w, input logic c45, input logic [4:0] phy,
                      input logic [4:0] rg, input logic [15:0] addr, input logic [15:0] wd);
    @(negedge clk);
    req_write = w; req_c45 = c45; req_phy = phy; req_reg = rg;
    req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    forever begin
      bit rdy;
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    // R2 busy right after the handshake
    chk(busy === 1'b1 && req_ready === 1'b0, "R2 busy after take", {busy, req_ready}, 2'b10);
  endtask

  task automatic txn(input logic w, input logic c45, input logic [4:0] phy,
                     input logic [4:0] rg, input logic [15:0] addr, input logic [15:0] wd,
                     input logic ta_bad, input logic [15:0] pdata);
    logic [1:0] op;
    rsp_t x;
    logic err;
    phy_ta_bad = ta_bad;
    phy_data = pdata;
    if (c45) begin
      frm_q.push_back(mk_frame(2'b00, 2'b00, phy, rg, addr, 0));
      op = w ? 2'b01 : 2'b11;
    end else begin
      op = w ? c22_wr_op : c22_rd_op;
    end
    frm_q.push_back(mk_frame(c45 ? 2'b00 : 2'b01, op, phy, rg, wd, !w));
    err = !w && ta_bad && !ta_ignore_mask[phy];
    x.e = err;
    x.d = w ? 16'h0 : (err ? 16'hFFFF : pdata);
    rsp_q.push_back(x);
    send(w, c45, phy, rg, addr, wd);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || rsp_q.size() != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 in reset
    chk(mdc == 0 && mdio_oe == 0 && busy == 0 && req_ready == 1 && rsp_done == 0,
        "R1 reset state", {mdc, mdio_oe, busy, req_ready, rsp_done}, 5'b00010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0 && busy == 0 && req_ready == 1 && rsp_done == 0,
        "R1 idle after reset", {mdc, mdio_oe, busy, req_ready, rsp_done}, 5'b00010);

    // R3 R4 R5 R11: short-form write
    txn(1, 0, 5'd5, 5'h1A, 16'h0, 16'hA5C3, 0, 16'h0);
    wait_idle();
    // R1 quiet between transactions
    chk(mdc == 0 && mdio_oe == 0, "R1 idle after write", {mdc, mdio_oe}, 2'b00);

    // R6: short-form read, good turnaround
    txn(0, 0, 5'd3, 5'd2, 16'h0, 16'h0, 0, 16'h1234);
    wait_idle();

    // R7: bad turnaround, mask bit for another PHY only
    ta_ignore_mask = 32'h0000_0040;
    txn(0, 0, 5'd7, 5'd1, 16'h0, 16'h0, 1, 16'h9999);
    wait_idle();

    // R8: bad turnaround exempted by mask
    ta_ignore_mask = 32'h0000_0080;
    txn(0, 0, 5'd7, 5'd1, 16'h0, 16'h0, 1, 16'hBEEF);
    wait_idle();
    ta_ignore_mask = 32'h0;

    // R9: extended write and read
    txn(1, 1, 5'd1, 5'd3, 16'h8001, 16'h0F0F, 0, 16'h0);
    wait_idle();
    txn(0, 1, 5'd2, 5'd1, 16'h0010, 16'h0, 0, 16'hCAFE);
    wait_idle();
    // R7 on an extended read
    txn(0, 1, 5'd30, 5'd7, 16'hFFFE, 16'h0, 1, 16'h0001);
    wait_idle();

    // R3: overridden short-form opcodes
    c22_rd_op = 2'b11; c22_wr_op = 2'b00;
    txn(0, 0, 5'd4, 5'd9, 16'h0, 16'h0, 0, 16'h5A5A);
    wait_idle();
    txn(1, 0, 5'd4, 5'd9, 16'h0, 16'h3C3C, 0, 16'h0);
    wait_idle();
    c22_rd_op = 2'b10; c22_wr_op = 2'b01;

    // R2: one-cycle pulse while busy is dropped; a held request waits
    txn(1, 0, 5'd6, 5'd4, 16'h0, 16'h1111, 0, 16'h0);
    repeat (200) @(negedge clk);
    req_write = 1'b1; req_c45 = 1'b0; req_phy = 5'd9; req_reg = 5'd9;
    req_wdata = 16'hDEAD; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1 && req_ready == 0, "R2 pulse while busy", {busy, req_ready}, 2'b10);
    txn(1, 0, 5'd8, 5'd5, 16'h0, 16'h2222, 0, 16'h0);
    wait_idle();

    repeat (20) @(negedge clk);
    chk(frm_q.size() == 0, "R2 all frames seen", 64'(frm_q.size()), 64'h0);
    chk(rsp_q.size() == 0 && busy == 0, "R2 all responses seen", 64'(rsp_q.size()), 64'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule